// File: doc/BRIEF.md
# Threshold Kernel Control Register Bank

This block is the software-facing control slave for a streaming image-thresholding kernel. A processor reaches it over AXI4-Lite. Through it the processor sets four run-time parameters: an 8-bit threshold, an 8-bit output level, a 32-bit row count and a 32-bit column count. It then launches a run and learns that the run is over, either by polling or through a level interrupt.

Toward the kernel the bank drives a start level and holds the four parameters steady. It takes back two one-cycle pulses:

- The ready pulse means the kernel has taken the start. The bank then drops start on its own, so the start bit cannot stay stuck at one.
- The done pulse means the run has finished. The bank then reports idle again.

Both events are latched for polling and also feed an interrupt path. That path has a global gate, a per-event enable and a status register whose bits flip when a one is written to them.

Top module: `thr_ctl_regs`

## Requirements
- R1: After reset the control word reads 0x4 (only idle set). Every other register reads zero, krn_start is low and irq is low.
- R2: Writing a word with bit 0 set to offset 0x00 (byte lane 0 enabled) raises krn_start. krn_start then stays high until the cycle in which krn_ready is high, and is low from the next cycle.
- R3: Idle (control bit 2) clears when krn_ready arrives while start is high. It is set again by a krn_done pulse.
- R4: The control word layout is bit 0 start, bit 1 done, bit 2 idle and bit 3 ready. Done and ready latch their pulses, and a read of offset 0x00 clears both. A read returns the values from before the clear.
- R5: Offset 0x04 bit 0 is the global interrupt enable. Offset 0x08 bits 1:0 are the per-event enables: bit 0 for done, bit 1 for ready. All other bits of both registers read zero.
- R6: Offset 0x0c is the status register. Bit 0 is set by a done pulse and bit 1 by a ready pulse. Writing a 1 to either bit inverts it. An event arriving in the same cycle as such a write wins.
- R7: irq is high exactly when the global enable is set and some status bit is set together with its enable bit.
- R8: Offset 0x10 bits 7:0 hold the threshold and offset 0x18 bits 7:0 hold the output level; their upper bits read zero. Offsets 0x20 and 0x28 hold the 32-bit row and column counts. All four appear on the krn_* parameter outputs.
- R9: Each write changes only the bytes whose strobe bit is set. A write with all strobes low changes nothing.
- R10: Reads of reserved offsets (0x14, 0x1c, 0x24, 0x2c) and of unmapped offsets return zero. Writes to them change no register. Every response is OKAY.
- R11: A write response or read response stays valid, with its data unchanged, until the master accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 6 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | 6 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| krn_start | output | 1 | Start level toward the kernel |
| krn_ready | input | 1 | Kernel took start (one-cycle pulse) |
| krn_done | input | 1 | Kernel finished a run (one-cycle pulse) |
| krn_thresh | output | 8 | Threshold parameter |
| krn_maxval | output | 8 | Output level parameter |
| krn_rows | output | 32 | Row count parameter |
| krn_cols | output | 32 | Column count parameter |
| irq | output | 1 | Level interrupt |

## Verification
A start bit that fails to clear shows up on krn_start in the cycle after the ready pulse, and in the next read of the control word. A lost idle or done latch appears in the first control read after the kernel's done pulse. A wrong status, enable or gate bit moves irq in the cycle after the event or write that caused it. A strobe or decode fault shows up at once, either in the read-back of that register or on the parameter outputs.

// File: rtl/thr_ctl_pkg.sv
package thr_ctl_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int EV_N   = 2;
    localparam int EV_DONE  = 0;
    localparam int EV_READY = 1;

    typedef enum logic [IDX_W-1:0] {
        RG_CTRL = 4'h0,
        RG_GIE  = 4'h1,
        RG_IER  = 4'h2,
        RG_ISR  = 4'h3,
        RG_THR  = 4'h4,
        RG_MAX  = 4'h6,
        RG_ROWS = 4'h8,
        RG_COLS = 4'hA
    } reg_idx_e;

    typedef struct packed {
        logic ready;
        logic idle;
        logic done;
        logic start;
    } ctrl_view_t;

    function automatic logic [DATA_W-1:0] strb_merge(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int b = 0; b < STRB_W; b++)
            if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/thr_hs_ctl.sv
module thr_hs_ctl
    import thr_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_wr,
    input  logic       ctrl_rd,
    input  logic       krn_ready,
    input  logic       krn_done,
    output ctrl_view_t view,
    output logic       krn_start
);
    ctrl_view_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{ready: 1'b0, idle: 1'b1, done: 1'b0, start: 1'b0};
        end else begin
            st_q.start <= start_wr | (st_q.start & ~krn_ready);
            if (krn_done)
                st_q.idle <= 1'b1;
            else if (st_q.start && krn_ready)
                st_q.idle <= 1'b0;
            st_q.done  <= krn_done  | (st_q.done  & ~ctrl_rd);
            st_q.ready <= krn_ready | (st_q.ready & ~ctrl_rd);
        end
    end

    assign view      = st_q;
    assign krn_start = st_q.start;

    // R2
    start_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (krn_start && krn_ready && !start_wr) |=> !krn_start);
    // R3
    idle_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        krn_done |=> view.idle);
endmodule

// File: rtl/thr_irq_unit.sv
module thr_irq_unit
    import thr_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            gie_we,
    input  logic            ier_we,
    input  logic            isr_we,
    input  logic [EV_N-1:0] wbits,
    input  logic [EV_N-1:0] ev,
    output logic            gie,
    output logic [EV_N-1:0] ier,
    output logic [EV_N-1:0] isr,
    output logic            irq
);
    logic [EV_N-1:0] flip;

    always_comb flip = isr_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie <= 1'b0;
            ier <= '0;
            isr <= '0;
        end else begin
            if (gie_we) gie <= wbits[0];
            if (ier_we) ier <= wbits;
            isr <= (isr ^ flip) | ev;
        end
    end

    assign irq = gie & |(isr & ier);

    // R6
    ev_latch_chk: assert property (@(posedge clk) disable iff (rst)
        ev[EV_READY] |=> isr[EV_READY]);
    // R7
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ev[EV_DONE] && ier[EV_DONE] && gie && !gie_we && !ier_we) |=> irq);
endmodule

// File: rtl/thr_ctl_regs.sv
module thr_ctl_regs
    import thr_ctl_pkg::*;
#(
    parameter int PAR_W = 8,
    parameter int DIM_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              krn_start,
    input  logic              krn_ready,
    input  logic              krn_done,
    output logic [PAR_W-1:0]  krn_thresh,
    output logic [PAR_W-1:0]  krn_maxval,
    output logic [DIM_W-1:0]  krn_rows,
    output logic [DIM_W-1:0]  krn_cols,
    output logic              irq
);
    logic [IDX_W-1:0] widx, ridx;
    logic wr_go, rd_go, lane0;
    logic unused_lo;
    logic [PAR_W-1:0] thr_q, max_q;
    logic [DIM_W-1:0] rows_q, cols_q;
    logic [DATA_W-1:0] rd_mux;
    ctrl_view_t view;
    logic gie;
    logic [EV_N-1:0] ier, isr;

    assign unused_lo = ^{s_awaddr[1:0], s_araddr[1:0]};
    assign widx  = s_awaddr[ADDR_W-1:2];
    assign ridx  = s_araddr[ADDR_W-1:2];
    assign wr_go = s_awvalid & s_wvalid & ~s_bvalid;
    assign rd_go = s_arvalid & ~s_rvalid;
    assign lane0 = wr_go & s_wstrb[0];

    assign s_awready = wr_go;
    assign s_wready  = wr_go;
    assign s_arready = rd_go;
    assign s_bresp   = 2'b00;
    assign s_rresp   = 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_bvalid <= 1'b0;
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else begin
            if (wr_go)         s_bvalid <= 1'b1;
            else if (s_bready) s_bvalid <= 1'b0;
            if (rd_go) begin
                s_rvalid <= 1'b1;
                s_rdata  <= rd_mux;
            end else if (s_rready) begin
                s_rvalid <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q  <= '0;
            max_q  <= '0;
            rows_q <= '0;
            cols_q <= '0;
        end else if (wr_go) begin
            if (lane0 && widx == RG_THR) thr_q <= s_wdata[PAR_W-1:0];
            if (lane0 && widx == RG_MAX) max_q <= s_wdata[PAR_W-1:0];
            if (widx == RG_ROWS) rows_q <= strb_merge(rows_q, s_wdata, s_wstrb);
            if (widx == RG_COLS) cols_q <= strb_merge(cols_q, s_wdata, s_wstrb);
        end
    end

    always_comb begin
        rd_mux = '0;
        case (ridx)
            RG_CTRL: rd_mux[3:0]       = view;
            RG_GIE:  rd_mux[0]         = gie;
            RG_IER:  rd_mux[EV_N-1:0]  = ier;
            RG_ISR:  rd_mux[EV_N-1:0]  = isr;
            RG_THR:  rd_mux[PAR_W-1:0] = thr_q;
            RG_MAX:  rd_mux[PAR_W-1:0] = max_q;
            RG_ROWS: rd_mux            = rows_q;
            RG_COLS: rd_mux            = cols_q;
            default: rd_mux            = '0;
        endcase
    end

    thr_hs_ctl u_hs (
        .clk       (clk),
        .rst       (rst),
        .start_wr  (lane0 && widx == RG_CTRL && s_wdata[0]),
        .ctrl_rd   (rd_go && ridx == RG_CTRL),
        .krn_ready (krn_ready),
        .krn_done  (krn_done),
        .view      (view),
        .krn_start (krn_start)
    );

    thr_irq_unit u_irq (
        .clk    (clk),
        .rst    (rst),
        .gie_we (lane0 && widx == RG_GIE),
        .ier_we (lane0 && widx == RG_IER),
        .isr_we (lane0 && widx == RG_ISR),
        .wbits  (s_wdata[EV_N-1:0]),
        .ev     ({krn_ready, krn_done}),
        .gie    (gie),
        .ier    (ier),
        .isr    (isr),
        .irq    (irq)
    );

    assign krn_thresh = thr_q;
    assign krn_maxval = max_q;
    assign krn_rows   = rows_q;
    assign krn_cols   = cols_q;

    // R11
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid);
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: tb/thr_ctl_regs_tb_top.sv
module thr_ctl_regs_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [5:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        krn_start, irq;
    logic        krn_ready = 0, krn_done = 0;
    logic [7:0]  krn_thresh, krn_maxval;
    logic [31:0] krn_rows, krn_cols;

    int total = 0, fails = 0;
    logic [31:0] rd_v;
    logic [1:0]  last_bresp;

    thr_ctl_regs dut_i (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .krn_start(krn_start), .krn_ready(krn_ready), .krn_done(krn_done),
        .krn_thresh(krn_thresh), .krn_maxval(krn_maxval),
        .krn_rows(krn_rows), .krn_cols(krn_cols), .irq(irq)
    );

    // address, data, strobes, expected read-back
    localparam int NV = 12;
    localparam logic [73:0] VEC [NV] = '{
        {6'h10, 32'hFFFFFF4B, 4'hF, 32'h0000004B},
        {6'h18, 32'h000000FF, 4'h1, 32'h000000FF},
        {6'h20, 32'h000009C0, 4'hF, 32'h000009C0},
        {6'h28, 32'h00000D20, 4'hF, 32'h00000D20},
        {6'h20, 32'hAABBCCDD, 4'h2, 32'h0000CCC0},
        {6'h28, 32'h11223344, 4'h8, 32'h11000D20},
        {6'h10, 32'h00000011, 4'h0, 32'h0000004B},
        {6'h14, 32'h12345678, 4'hF, 32'h00000000},
        {6'h04, 32'hFFFFFFFF, 4'hF, 32'h00000001},
        {6'h08, 32'hFFFFFFFF, 4'hF, 32'h00000003},
        {6'h3C, 32'h0000FFFF, 4'hF, 32'h00000000},
        {6'h2C, 32'hFFFFFFFF, 4'hF, 32'h00000000}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        awvalid = 0; wvalid = 0; bready = 1;
        while (!bvalid) @(negedge clk);
        last_bresp = bresp;
        @(posedge clk); #1;
        bready = 0;
    endtask

    task automatic axi_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        arvalid = 0; rready = 1;
        while (!rvalid) @(negedge clk);
        d = rdata;
        chk({30'd0, rresp}, 32'd0, "R10 read response OKAY");
        @(posedge clk); #1;
        rready = 0;
    endtask

    // kernel model: ready three cycles after start, done ten cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && krn_start) begin
                repeat (3) @(negedge clk);
                krn_ready = 1;
                @(negedge clk);
                krn_ready = 0;
                repeat (10) @(negedge clk);
                krn_done = 1;
                @(negedge clk);
                krn_done = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({31'd0, krn_start}, 0, "R1 krn_start after reset");
        chk({31'd0, irq}, 0, "R1 irq after reset");
        axi_rd(6'h00, rd_v); chk(rd_v, 32'h4, "R1 control word after reset");
        axi_rd(6'h0C, rd_v); chk(rd_v, 32'h0, "R1 status after reset");
        axi_rd(6'h20, rd_v); chk(rd_v, 32'h0, "R1 rows after reset");

        // R8 R9 R10 R5 register table
        for (int i = 0; i < NV; i++) begin
            axi_wr(VEC[i][73:68], VEC[i][67:36], VEC[i][35:32]);
            chk({30'd0, last_bresp}, 0, "R10 write response OKAY");
            axi_rd(VEC[i][73:68], rd_v);
            chk(rd_v, VEC[i][31:0], "R8 R9 R10 R5 table read-back");
        end
        @(negedge clk);
        chk({24'd0, krn_thresh}, 32'h4B, "R8 threshold port");
        chk({24'd0, krn_maxval}, 32'hFF, "R8 output level port");
        chk(krn_rows, 32'h0000CCC0, "R8 R9 rows port");
        chk(krn_cols, 32'h11000D20, "R8 R9 cols port");
        chk({31'd0, irq}, 0, "R7 no status, no irq");
        chk({31'd0, krn_start}, 0, "R10 unmapped writes leave start low");

        // R2 R3 R4 one run
        axi_wr(6'h00, 32'h1, 4'h1);
        chk({31'd0, krn_start}, 1, "R2 start raised");
        @(posedge krn_ready);
        @(negedge clk);
        chk({31'd0, krn_start}, 0, "R2 start dropped after ready");
        axi_rd(6'h00, rd_v); chk(rd_v, 32'h8, "R3 R4 running: ready latched, idle low");
        @(posedge krn_done);
        @(negedge clk);
        axi_rd(6'h00, rd_v); chk(rd_v, 32'h6, "R3 R4 finished: done and idle");
        axi_rd(6'h00, rd_v); chk(rd_v, 32'h4, "R4 done cleared by read");
        axi_rd(6'h0C, rd_v); chk(rd_v, 32'h3, "R6 both events latched");
        chk({31'd0, irq}, 1, "R7 irq with both enabled");

        // R6 R7 toggle behaviour
        axi_wr(6'h0C, 32'h1, 4'h1);
        axi_rd(6'h0C, rd_v); chk(rd_v, 32'h2, "R6 toggle clears done bit");
        chk({31'd0, irq}, 1, "R7 ready status keeps irq");
        axi_wr(6'h0C, 32'h2, 4'h1);
        @(negedge clk);
        chk({31'd0, irq}, 0, "R7 irq low with empty status");
        axi_wr(6'h0C, 32'h1, 4'h1);
        axi_rd(6'h0C, rd_v); chk(rd_v, 32'h1, "R6 toggle sets done bit");
        axi_wr(6'h0C, 32'h1, 4'h0);
        axi_rd(6'h0C, rd_v); chk(rd_v, 32'h1, "R9 status write without strobe ignored");

        // R7 gating
        axi_wr(6'h04, 32'h0, 4'h1);
        @(negedge clk);
        chk({31'd0, irq}, 0, "R7 global enable off masks irq");
        axi_wr(6'h04, 32'h1, 4'h1);
        axi_wr(6'h08, 32'h2, 4'h1);
        @(negedge clk);
        chk({31'd0, irq}, 0, "R7 done disabled masks irq");
        axi_wr(6'h08, 32'h1, 4'h1);
        @(negedge clk);
        chk({31'd0, irq}, 1, "R7 done enabled raises irq");

        // R11 held read response
        @(negedge clk);
        araddr = 6'h18; arvalid = 1;
        @(posedge clk); #1;
        arvalid = 0;
        repeat (3) @(negedge clk);
        chk({31'd0, rvalid}, 1, "R11 read valid held");
        chk(rdata, 32'hFF, "R11 read data held");
        rready = 1;
        @(posedge clk); #1;
        rready = 0;
        @(negedge clk);
        chk({31'd0, rvalid}, 0, "R11 read valid released");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule